// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side control that takes an interrupt and later returns from it. It owns the program counter, the processor status word and two banked stack pointers: one for user code and one for supervisor code. At each instruction boundary it looks at the interrupt line. If it accepts a request, it saves the status word and the program counter on the supervisor stack. It then moves to supervisor privilege at the priority of the request and fetches the service routine address from a vector table.

A return command at a boundary runs the reverse. The saved PC and status word are popped from the supervisor stack, and this restores the earlier privilege mode. Because the privilege bit selects the stack pointer, interrupt state never lands on the user stack.

While a sequence runs, `busy` holds off the normal fetch. The surrounding core loads the PC, the condition codes and the active stack pointer through simple load strobes, and these take effect only while the block is idle. All stack and table traffic goes through a single-word memory port. Each access takes one cycle, and read data returns on the cycle after the request.

Top module: `isr_seq_top`

## Requirements
- R1: After reset the PC is 0x3000, the status word is 0x8002, the visible stack pointer is the user one at 0xFE00, the supervisor pointer is 0x2FF0, and `busy` and `mem_req` are low.
- R2: The interrupt line is considered only on a cycle where `boundary` is high and `busy` is low. A request seen without `boundary` has no effect.
- R3: A request is accepted only when `irq_level` is strictly greater than the status word's priority field, bits 10:8. A request at or below that level is ignored: PC, status word and `busy` stay unchanged.
- R4: On entry, the supervisor pointer is pre-incremented before each write. The old status word is written at SSP+1 and the old PC at SSP+2, with the status word first. SSP ends two higher, and the user pointer is untouched, whichever mode was running before.
- R5: On entry, the status word gets bit 15 = 0 (supervisor) and bits 10:8 = the accepted level. Every other bit keeps its value, including the condition codes in bits 2:0.
- R6: After entry, the PC holds the word read from address 0x0100 + `irq_vec`, for every vector from 0x00 to 0xFF.
- R7: `busy` is high for exactly 4 cycles on entry and 3 cycles on return. PC, condition-code and stack-pointer loads presented while busy have no effect.
- R8: On return, the PC is loaded from the word at SSP, then the status word from the word at SSP-1. SSP ends two lower.
- R9: `sp_out` shows the user pointer when status bit 15 is 1 and the supervisor pointer when it is 0. `sp_ld` writes only that pointer. `pc_ld` and `cc_ld` (status bits 2:0) take effect at the next edge while idle.
- R10: A return command while status bit 15 is 1 (user mode) is ignored.
- R11: When a valid return command and an acceptable request arrive at the same boundary, the return runs and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Store phase done, next fetch pending |
| irq_req | input | 1 | Interrupt request line |
| irq_level | input | 3 | Priority of the pending request |
| irq_vec | input | 8 | Vector identifying the requester |
| rti_cmd | input | 1 | Return-from-interrupt command at the boundary |
| pc_ld | input | 1 | Core PC load strobe |
| pc_in | input | 16 | Core PC load value |
| cc_ld | input | 1 | Core condition-code load strobe |
| cc_in | input | 3 | Condition-code value (bits 2:0 of status) |
| sp_ld | input | 1 | Load the active stack pointer |
| sp_in | input | 16 | Stack pointer load value |
| busy | output | 1 | Sequence in progress, hold fetch |
| pc_out | output | 16 | Current PC |
| psr_out | output | 16 | Current status word |
| sp_out | output | 16 | Active stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
The bench targets equal-priority requests. A design that compared with greater-or-equal would nest an interrupt at the same level. It checks the push order and the slot addresses: a post-increment or a swapped order would put the PC where the return expects the status word, and would resume at a status value. It also checks entry from supervisor mode, the extreme vectors 0x00 and 0xFF, and a return and a request arriving together. A design that chose the stack by the old mode would write to the user stack. A design that favoured the request would nest instead of unwinding. Core loads presented mid-sequence must not overwrite the vector PC.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSR,
    ST_PUSH_PC,
    ST_VEC_RD,
    ST_VEC_LD,
    ST_POP_PC,
    ST_POP_PSR,
    ST_PSR_LD
  } seq_state_e;

  // status word layout, fixed by the decode that reads it
  localparam int PRIV_POS = 15;
  localparam int PL_LSB   = 8;
  localparam int PL_W     = 3;
  localparam int PL_MSB   = PL_LSB + PL_W - 1;
  localparam int CC_W     = 3;
endpackage

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
  import isr_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary,
  input  logic            irq_req,
  input  logic [PL_W-1:0] irq_level,
  input  logic            rti_cmd,
  input  logic            cur_priv,
  input  logic [PL_W-1:0] cur_pl,
  output seq_state_e      state_q,
  output logic            start_entry,
  output logic            start_return
);
  seq_state_e state_d;
  logic       idle;

  assign idle         = (state_q == ST_IDLE);
  // return wins over a request at the same boundary; user-mode return is dropped
  assign start_return = idle && boundary && rti_cmd && !cur_priv;
  assign start_entry  = idle && boundary && irq_req && !start_return &&
                        (irq_level > cur_pl);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_return)     state_d = ST_POP_PC;
        else if (start_entry) state_d = ST_PUSH_PSR;
      end
      ST_PUSH_PSR: state_d = ST_PUSH_PC;
      ST_PUSH_PC:  state_d = ST_VEC_RD;
      ST_VEC_RD:   state_d = ST_VEC_LD;
      ST_VEC_LD:   state_d = ST_IDLE;
      ST_POP_PC:   state_d = ST_POP_PSR;
      ST_POP_PSR:  state_d = ST_PSR_LD;
      ST_PSR_LD:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/isr_sp_bank.sv
module isr_sp_bank #(
  parameter int              WORD_W   = 16,
  parameter logic [WORD_W-1:0] USP_INIT = 16'hFE00,
  parameter logic [WORD_W-1:0] SSP_INIT = 16'h2FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_sel,   // 1 = user bank, 0 = supervisor bank
  input  logic              core_wr,
  input  logic [WORD_W-1:0] core_data,
  input  logic              ssp_inc,
  input  logic              ssp_dec,
  output logic [WORD_W-1:0] active_sp,
  output logic [WORD_W-1:0] ssp_sp
);
  localparam int NBANK = 2;
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  // bank index equals the privilege bit value
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [WORD_W-1:0] INIT = (b == 1) ? USP_INIT : SSP_INIT;
    localparam bit IS_SUP = (b == 0);
    logic [WORD_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)                                   q <= INIT;
      else if (core_wr && (active_sel == 1'(b))) q <= core_data;
      else if (IS_SUP && ssp_inc)                q <= q + ONE;
      else if (IS_SUP && ssp_dec)                q <= q - ONE;
    end
  end

  assign ssp_sp    = g_bank[0].q;
  assign active_sp = active_sel ? g_bank[1].q : g_bank[0].q;
endmodule

// File: rtl/isr_psr_pc.sv
module isr_psr_pc
  import isr_seq_pkg::*;
#(
  parameter int                WORD_W    = 16,
  parameter logic [WORD_W-1:0] RESET_PC  = 16'h3000,
  parameter logic [WORD_W-1:0] RESET_PSR = 16'h8002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_en,
  input  logic              pc_ld,
  input  logic [WORD_W-1:0] pc_in,
  input  logic              cc_ld,
  input  logic [CC_W-1:0]   cc_in,
  input  logic              entry_start,
  input  logic [PL_W-1:0]   entry_level,
  input  logic              pc_from_mem,
  input  logic              psr_from_mem,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] psr_q,
  output logic [WORD_W-1:0] save_pc_q,
  output logic [WORD_W-1:0] save_psr_q
);
  logic [WORD_W-1:0] psr_entry;

  always_comb begin
    psr_entry                 = psr_q;
    psr_entry[PRIV_POS]       = 1'b0;
    psr_entry[PL_MSB:PL_LSB]  = entry_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
    end else if (pc_from_mem) begin
      pc_q <= mem_word;
    end else if (core_en && pc_ld) begin
      pc_q <= pc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q <= RESET_PSR;
    end else if (entry_start) begin
      psr_q <= psr_entry;
    end else if (psr_from_mem) begin
      psr_q <= mem_word;
    end else if (core_en && cc_ld) begin
      psr_q[CC_W-1:0] <= cc_in;
    end
  end

  // snapshot of the interrupted context, written out by the two pushes
  always_ff @(posedge clk) begin
    if (rst) begin
      save_pc_q  <= '0;
      save_psr_q <= '0;
    end else if (entry_start) begin
      save_pc_q  <= pc_q;
      save_psr_q <= psr_q;
    end
  end
endmodule

// File: rtl/isr_seq_top.sv
module isr_seq_top
  import isr_seq_pkg::*;
#(
  parameter int                WORD_W    = 16,
  parameter int                VEC_W     = 8,
  parameter logic [WORD_W-1:0] VT_BASE   = 16'h0100,
  parameter logic [WORD_W-1:0] RESET_PC  = 16'h3000,
  parameter logic [WORD_W-1:0] RESET_PSR = 16'h8002,
  parameter logic [WORD_W-1:0] USP_INIT  = 16'hFE00,
  parameter logic [WORD_W-1:0] SSP_INIT  = 16'h2FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              irq_req,
  input  logic [2:0]        irq_level,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              rti_cmd,
  input  logic              pc_ld,
  input  logic [WORD_W-1:0] pc_in,
  input  logic              cc_ld,
  input  logic [2:0]        cc_in,
  input  logic              sp_ld,
  input  logic [WORD_W-1:0] sp_in,
  output logic              busy,
  output logic [WORD_W-1:0] pc_out,
  output logic [WORD_W-1:0] psr_out,
  output logic [WORD_W-1:0] sp_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  seq_state_e        state_q;
  logic              start_entry, start_return, core_en;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] pc_q, psr_q, save_pc_q, save_psr_q, ssp_q, active_sp;
  logic              ssp_inc, ssp_dec, pc_from_mem, psr_from_mem;

  isr_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .boundary     (boundary),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .rti_cmd      (rti_cmd),
    .cur_priv     (psr_q[PRIV_POS]),
    .cur_pl       (psr_q[PL_MSB:PL_LSB]),
    .state_q      (state_q),
    .start_entry  (start_entry),
    .start_return (start_return)
  );

  assign core_en = (state_q == ST_IDLE) && !start_entry && !start_return;

  always_ff @(posedge clk) begin
    if (rst)              vec_q <= '0;
    else if (start_entry) vec_q <= irq_vec;
  end

  assign ssp_inc      = (state_q == ST_PUSH_PSR) || (state_q == ST_PUSH_PC);
  assign ssp_dec      = (state_q == ST_POP_PC)   || (state_q == ST_POP_PSR);
  assign pc_from_mem  = (state_q == ST_VEC_LD)   || (state_q == ST_POP_PSR);
  assign psr_from_mem = (state_q == ST_PSR_LD);

  isr_psr_pc #(
    .WORD_W    (WORD_W),
    .RESET_PC  (RESET_PC),
    .RESET_PSR (RESET_PSR)
  ) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .core_en      (core_en),
    .pc_ld        (pc_ld),
    .pc_in        (pc_in),
    .cc_ld        (cc_ld),
    .cc_in        (cc_in),
    .entry_start  (start_entry),
    .entry_level  (irq_level),
    .pc_from_mem  (pc_from_mem),
    .psr_from_mem (psr_from_mem),
    .mem_word     (mem_rdata),
    .pc_q         (pc_q),
    .psr_q        (psr_q),
    .save_pc_q    (save_pc_q),
    .save_psr_q   (save_psr_q)
  );

  isr_sp_bank #(
    .WORD_W   (WORD_W),
    .USP_INIT (USP_INIT),
    .SSP_INIT (SSP_INIT)
  ) u_sp (
    .clk        (clk),
    .rst        (rst),
    .active_sel (psr_q[PRIV_POS]),
    .core_wr    (core_en && sp_ld),
    .core_data  (sp_in),
    .ssp_inc    (ssp_inc),
    .ssp_dec    (ssp_dec),
    .active_sp  (active_sp),
    .ssp_sp     (ssp_q)
  );

  // memory port decoded from the registered state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_PSR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = ssp_q + ONE; mem_wdata = save_psr_q;
      end
      ST_PUSH_PC: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = ssp_q + ONE; mem_wdata = save_pc_q;
      end
      ST_VEC_RD: begin
        mem_req = 1'b1; mem_addr = VT_BASE + WORD_W'(vec_q);
      end
      ST_POP_PC, ST_POP_PSR: begin
        mem_req = 1'b1; mem_addr = ssp_q;
      end
      default: ;
    endcase
  end

  assign busy    = (state_q != ST_IDLE);
  assign pc_out  = pc_q;
  assign psr_out = psr_q;
  assign sp_out  = active_sp;
endmodule

// File: rtl/isr_seq_chk.sv
module isr_seq_chk #(
  parameter int                WORD_W  = 16,
  parameter int                VEC_W   = 8,
  parameter logic [WORD_W-1:0] VT_BASE = 16'h0100
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              psr_priv,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr
);
  localparam logic [WORD_W-1:0] ONE     = {{(WORD_W-1){1'b0}}, 1'b1};
  localparam logic [WORD_W-1:0] VT_LAST = VT_BASE + WORD_W'((1 << VEC_W) - 1);

  AST_NO_USER_PUSH: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !psr_priv); // R4

  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) + ONE)); // R4

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> (mem_req && mem_addr >= VT_BASE && mem_addr <= VT_LAST)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R7

  AST_POP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> mem_addr == $past(mem_addr) - ONE); // R8
endmodule

bind isr_seq_top isr_seq_chk #(
  .WORD_W  (WORD_W),
  .VEC_W   (VEC_W),
  .VT_BASE (VT_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .psr_priv (psr_out[15]),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/isr_seq_tb.sv
`timescale 1ns/1ps
module isr_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        boundary, irq_req, rti_cmd, pc_ld, cc_ld, sp_ld;
  logic [2:0]  irq_level, cc_in;
  logic [7:0]  irq_vec;
  logic [15:0] pc_in, sp_in;
  logic        busy, mem_req, mem_we;
  logic [15:0] pc_out, psr_out, sp_out, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'h0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] m_pc, m_psr, m_usp, m_ssp;
  logic [15:0] mem_m [logic [15:0]];

  always #2 clk = ~clk;

  isr_seq_top dut_i (
    .clk(clk), .rst(rst), .boundary(boundary), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vec(irq_vec), .rti_cmd(rti_cmd),
    .pc_ld(pc_ld), .pc_in(pc_in), .cc_ld(cc_ld), .cc_in(cc_in),
    .sp_ld(sp_ld), .sp_in(sp_in), .busy(busy), .pc_out(pc_out),
    .psr_out(psr_out), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] vec_word(input logic [7:0] v);
    return 16'h4000 + 16'(v) * 16'd7;
  endfunction

  function automatic logic [15:0] act_sp();
    return m_psr[15] ? m_usp : m_ssp;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_m[mem_addr] = mem_wdata;
      else        mem_rdata <= rd(mem_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    boundary = 0; irq_req = 0; irq_level = 0; irq_vec = 0; rti_cmd = 0;
    pc_ld = 0; pc_in = 0; cc_ld = 0; cc_in = 0; sp_ld = 0; sp_in = 0;
  endtask

  task automatic check_ctx(input string tag);
    chk({tag, " pc"},  pc_out,  m_pc);
    chk({tag, " psr"}, psr_out, m_psr);
    chk({tag, " sp"},  sp_out,  act_sp());
  endtask

  // R9: core loads, applied at the next edge while idle
  task automatic core_op(input bit lp, input logic [15:0] pv, input bit lc,
                         input logic [2:0] cv, input bit ls, input logic [15:0] sv);
    pc_ld = lp; pc_in = pv; cc_ld = lc; cc_in = cv; sp_ld = ls; sp_in = sv;
    @(posedge clk); @(negedge clk);
    clear_in();
    if (lp) m_pc = pv;
    if (lc) m_psr[2:0] = cv;
    if (ls) begin
      if (m_psr[15]) m_usp = sv; else m_ssp = sv;
    end
    check_ctx("R9 core load");
  endtask

  // one boundary with optional request and return command
  task automatic boundary_op(input bit irq, input logic [2:0] lvl, input logic [7:0] vec,
                             input bit rti, input bit poke, input string tag);
    bit ret_ok, ent_ok;
    int n;
    logic [15:0] old_pc, old_psr;
    ret_ok  = rti && !m_psr[15];
    ent_ok  = !ret_ok && irq && (lvl > m_psr[10:8]);
    old_pc  = m_pc;
    old_psr = m_psr;
    boundary = 1; irq_req = irq; irq_level = lvl; irq_vec = vec; rti_cmd = rti;
    @(posedge clk); @(negedge clk);
    clear_in();
    n = 0;
    while (busy && n < 16) begin
      if (poke) begin
        pc_ld = 1; pc_in = 16'hDEAD; cc_ld = 1; cc_in = ~m_psr[2:0];
        sp_ld = 1; sp_in = 16'h1234;
      end
      n++;
      @(negedge clk);
    end
    clear_in();
    if (ret_ok) begin
      chk({tag, " R7 return busy cycles"}, n, 3);
      m_pc  = rd(m_ssp);
      m_psr = rd(m_ssp - 16'd1);
      m_ssp = m_ssp - 16'd2;
      check_ctx({tag, " R8 return"});
    end else if (ent_ok) begin
      chk({tag, " R7 entry busy cycles"}, n, 4);
      chk({tag, " R4 psr slot"}, rd(m_ssp + 16'd1), old_psr);
      chk({tag, " R4 pc slot"},  rd(m_ssp + 16'd2), old_pc);
      m_ssp = m_ssp + 16'd2;
      m_psr = {1'b0, old_psr[14:11], lvl, old_psr[7:0]};
      m_pc  = vec_word(vec);
      chk({tag, " R5 psr"}, psr_out, m_psr);
      chk({tag, " R6 pc"},  pc_out,  m_pc);
      chk({tag, " R4 ssp"}, sp_out,  m_ssp);
    end else begin
      chk({tag, " no sequence busy"}, n, 0);
      check_ctx({tag, " unchanged"});
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    clear_in();
    for (int v = 0; v < 256; v++) mem_m[16'h0100 + 16'(v)] = vec_word(8'(v));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_pc = 16'h3000; m_psr = 16'h8002; m_usp = 16'hFE00; m_ssp = 16'h2FF0;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    check_ctx("R1 reset");

    core_op(1, 16'h3050, 1, 3'b001, 1, 16'hFD00);

    // R2 request without boundary
    irq_req = 1; irq_level = 3'd7; irq_vec = 8'h22;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R2 no boundary busy", busy, 0);
    end
    clear_in();
    check_ctx("R2 no boundary");

    boundary_op(1, 3'd0, 8'h10, 0, 0, "R3 level0 vs pl0");
    boundary_op(1, 3'd2, 8'h80, 0, 1, "R7 poke entry");
    boundary_op(1, 3'd2, 8'h81, 0, 0, "R3 equal level");
    boundary_op(1, 3'd5, 8'hFF, 0, 0, "R4 nested vec FF");
    boundary_op(0, 3'd0, 8'h00, 1, 1, "R8 poke return");
    boundary_op(1, 3'd7, 8'h33, 1, 0, "R11 return wins");
    chk("R11 user mode restored", psr_out[15], 1);
    boundary_op(0, 3'd0, 8'h00, 1, 0, "R10 user rti");
    boundary_op(1, 3'd1, 8'h00, 0, 0, "R6 vec 00");
    core_op(0, 16'h0, 0, 3'b0, 1, 16'h2E00);   // R9 writes supervisor pointer
    boundary_op(0, 3'd0, 8'h00, 1, 0, "R8 return after ssp load");

    for (int it = 0; it < 120; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: core_op($urandom % 2, 16'($urandom), $urandom % 2, 3'($urandom),
                   $urandom % 2, 16'h2000 + 16'($urandom % 4096));
        1, 2: boundary_op(1, 3'($urandom), 8'($urandom), 0, $urandom % 2, "R3 random irq");
        3: boundary_op(0, 3'd0, 8'h00, 1, 0, "R8 random rti");
        default: boundary_op(1, 3'($urandom), 8'($urandom), 1, 0, "R11 random both");
      endcase
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule